// File: doc/BRIEF.md
# Parallel Port IDE Bridge Slave

This block is the device side of an adapter that carries IDE register traffic over an ordinary parallel port. The host has only its 8-bit data lines and its control lines to talk with. It selects a register by putting an address byte on the data lines and stepping the control lines through a fixed pattern. A single write is a second control pattern. A single read comes back four bits at a time on status lines 7:4, low nibble first. A byte-wide burst read can be started instead: the host releases the data lines and the bridge drives one byte per control step.

Both the control lines and the data lines pass through a two-flop synchroniser. Only changes of the synchronised control value count as events, so the protocol is defined by the order of distinct control values and not by how long each is held. On the drive side the block offers a small register-file interface: a bank select, a 3-bit register index, write data, read data, and one-cycle read and write strobes. Before any register is selected, the status lines give a fixed identification response that marks the bridge as the ASIC type.

Top module: `ppide_bridge`

## Requirements
- R1: After reset pp_data_oe, ide_rd and ide_wr are 0 and pp_status is 0x00.
- R2: The control events 0x0C, 0x0E, 0x0C, 0x04 in that order latch the data byte present at the 0x04 event. A byte 0x08+n selects bank 0 register n (ide_alt=0, ide_idx=n) and a byte 0x10+n selects bank 1 register n (ide_alt=1). Any other byte except 0x20 and the burst codes leaves nothing selected.
- R3: With a register selected, control 0x06 issues exactly one read strobe and pp_status becomes {low nibble, 0000}. The next 0x04 makes pp_status {high nibble, 0000}.
- R4: Repeated 0x06/0x04 pairs after one latch each read the same register again. Bank 0 register 0 acts as a data port that returns successive bytes.
- R5: The control events 0x05, 0x07, 0x05, 0x04 with a register selected issue exactly one write strobe when the final 0x04 arrives. The data written is the byte present at the 0x07 event.
- R6: A control value that breaks a partial latch or write pattern cancels it. No strobe fires and the selection does not change.
- R7: A latched byte 0xC0+a, where a is 0x08..0x17, starts a burst on the register that a selects. While the burst runs, each 0xA6 or 0xA4 event reads one byte and puts it on pp_data_out. pp_data_oe is 1 only while a burst is active and control bit 5 is 1.
- R8: Control 0xAC followed by 0xA4 ends the burst, and neither of these two events reads. pp_data_oe falls once control returns to 0x04.
- R9: A latched byte 0x20 disconnects the bridge. Nothing is selected, pp_data_oe is 0, and a following 0x06 issues no read.
- R10: With nothing selected, status bit 6 is 0 after a 0x06 or 0x07 event and 1 after a 0x04 event. pp_status is then {0100, 0000} or 0x00.
- R11: A control value held for any number of cycles counts as a single event. A repeated value adds no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pp_ctrl | input | 8 | Host control-line value (bit 5 = host has released data lines) |
| pp_data_in | input | 8 | Host data lines as driven by the host |
| pp_data_out | output | 8 | Byte driven onto the data lines during a burst |
| pp_data_oe | output | 1 | Drive enable for pp_data_out |
| pp_status | output | 8 | Status lines; bits 7:4 carry the returned nibble |
| ide_alt | output | 1 | Register bank select (0 = register file, 1 = command set) |
| ide_idx | output | 3 | Register index within the bank |
| ide_wdata | output | 8 | Write data |
| ide_rdata | input | 8 | Read data from the selected register |
| ide_rd | output | 1 | One-cycle read strobe |
| ide_wr | output | 1 | One-cycle write strobe |

## Verification
The hardest cases to reach are the control patterns that look almost like a latch or a write but are not one. Examples are a write cut short by an address-step value, a latch whose last step is a read step, and a value repeated inside a pattern, which must not count twice. To reach them, the bench steps the control lines through such broken sequences on a live selection. It then reads the selected register back through the nibble path, so a stray write or a stray re-selection shows up at the status lines and in the strobe counts. Changing the data lines between the 0x07 and 0x04 steps of a write shows which byte was captured.

// File: rtl/ppide_pkg.sv
package ppide_pkg;

  localparam int IDX_W = 3;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {SEL_NONE, SEL_FILE, SEL_BURST, SEL_DROP} sel_e;
  typedef enum logic [1:0] {BP_OFF, BP_RUN, BP_TAIL, BP_DONE} bph_e;

  typedef struct packed {
    sel_e             kind;
    logic             alt;
    logic [IDX_W-1:0] idx;
  } target_t;

  // control codes the bridge reacts to
  localparam logic [7:0] CT_IDLE    = 8'h04;
  localparam logic [7:0] CT_WR_A    = 8'h05;
  localparam logic [7:0] CT_NIB_LO  = 8'h06;
  localparam logic [7:0] CT_WR_B    = 8'h07;
  localparam logic [7:0] CT_ADR_A   = 8'h0C;
  localparam logic [7:0] CT_ADR_B   = 8'h0E;
  localparam logic [7:0] CT_BST_EVN = 8'hA4;
  localparam logic [7:0] CT_BST_ODD = 8'hA6;
  localparam logic [7:0] CT_BST_END = 8'hAC;

  localparam logic [7:0] AD_DROP = 8'h20;
  localparam logic [NIB_W-1:0] ID_HIGH = 4'b0100;

  // latch patterns, newest event in the lowest byte
  localparam logic [31:0] PAT_ADDR  = {CT_ADR_A, CT_ADR_B, CT_ADR_A, CT_IDLE};
  localparam logic [31:0] PAT_WRITE = {CT_WR_A, CT_WR_B, CT_WR_A, CT_IDLE};

  function automatic target_t decode_target(input logic [7:0] a);
    target_t t;
    t.kind = SEL_NONE;
    t.alt  = a[4];
    t.idx  = a[IDX_W-1:0];
    if (a == AD_DROP)
      t.kind = SEL_DROP;
    else if (a[7:6] == 2'b11 && (a[5:3] == 3'b001 || a[5:3] == 3'b010))
      t.kind = SEL_BURST;
    else if (a[7:3] == 5'b00001 || a[7:3] == 5'b00010)
      t.kind = SEL_FILE;
    return t;
  endfunction

  function automatic logic [7:0] nibble_view(input logic [7:0] b, input logic hi);
    return hi ? {b[7:4], 4'h0} : {b[3:0], 4'h0};
  endfunction

endpackage

// File: rtl/ppide_sync.sv
module ppide_sync #(
  parameter int         W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ppide_seqmatch.sv
module ppide_seqmatch #(
  parameter int             W       = 8,
  parameter int             LEN     = 4,
  parameter logic [LEN*W-1:0] PATTERN = '0,
  parameter int             CAP_AGE = 0,
  parameter logic [W-1:0]   FILL    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic [W-1:0] val,
  input  logic [W-1:0] data,
  output logic         hit,
  output logic [W-1:0] cap
);
  localparam int HN = LEN - 1;

  logic [W-1:0]   vh [HN];
  logic [LEN-1:0] ok;

  assign ok[0] = (val == PATTERN[0 +: W]);

  generate
    for (genvar k = 1; k < LEN; k++) begin : g_slot
      assign ok[k] = (vh[k-1] == PATTERN[k*W +: W]);
    end
  endgenerate

  assign hit = ev && (&ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < HN; k++) vh[k] <= FILL;
    end else if (ev) begin
      vh[0] <= val;
      for (int k = 1; k < HN; k++) vh[k] <= vh[k-1];
    end
  end

  generate
    if (CAP_AGE == 0) begin : g_cap_now
      assign cap = data;
    end else begin : g_cap_old
      logic [W-1:0] dh [CAP_AGE];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < CAP_AGE; k++) dh[k] <= '0;
        end else if (ev) begin
          dh[0] <= data;
          for (int k = 1; k < CAP_AGE; k++) dh[k] <= dh[k-1];
        end
      end
      assign cap = dh[CAP_AGE-1];
    end
  endgenerate
endmodule

// File: rtl/ppide_xfer.sv
module ppide_xfer
  import ppide_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic [CW-1:0] ev_val,
  input  logic          ctl_bit5,
  input  logic          latch_hit,
  input  logic [DW-1:0] latch_byte,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_byte,
  input  logic [DW-1:0] rdata,
  output logic          ide_rd,
  output logic          ide_wr,
  output logic          ide_alt,
  output logic [IW-1:0] ide_idx,
  output logic [DW-1:0] ide_wdata,
  output logic [DW-1:0] status,
  output logic [DW-1:0] dout,
  output logic          oe,
  output sel_e          sel_o,
  output bph_e          bph_o
);
  localparam int NW = DW / 2;

  sel_e          sel_q;
  bph_e          bph_q;
  logic          alt_q, hi_q, to_bus_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] byte_q;
  logic [NW-1:0] id_q;
  target_t       tgt;
  logic          fetch_nib, fetch_bus, do_write;

  always_comb begin
    tgt       = decode_target(latch_byte);
    fetch_nib = ev && !latch_hit && sel_q == SEL_FILE && ev_val == CT_NIB_LO;
    fetch_bus = ev && !latch_hit && sel_q == SEL_BURST && bph_q == BP_RUN &&
                (ev_val == CT_BST_ODD || ev_val == CT_BST_EVN);
    do_write  = wr_hit && sel_q == SEL_FILE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= SEL_NONE;
      bph_q     <= BP_OFF;
      alt_q     <= 1'b0;
      idx_q     <= '0;
      hi_q      <= 1'b0;
      to_bus_q  <= 1'b0;
      ide_rd    <= 1'b0;
      ide_wr    <= 1'b0;
      ide_wdata <= '0;
      byte_q    <= '0;
      dout      <= '0;
      id_q      <= '0;
    end else begin
      ide_rd   <= fetch_nib | fetch_bus;
      to_bus_q <= fetch_bus;
      ide_wr   <= do_write;
      if (do_write) ide_wdata <= wr_byte;
      if (ide_rd) begin
        if (to_bus_q) dout   <= rdata;
        else          byte_q <= rdata;
      end
      if (latch_hit) begin
        alt_q <= tgt.alt;
        idx_q <= tgt.idx;
        hi_q  <= 1'b0;
        case (tgt.kind)
          SEL_FILE:  begin sel_q <= SEL_FILE;  bph_q <= BP_OFF; end
          SEL_BURST: begin sel_q <= SEL_BURST; bph_q <= BP_RUN; end
          default:   begin sel_q <= SEL_NONE;  bph_q <= BP_OFF; end
        endcase
      end else if (ev) begin
        case (sel_q)
          SEL_FILE: begin
            if (ev_val == CT_NIB_LO)    hi_q <= 1'b0;
            else if (ev_val == CT_IDLE) hi_q <= 1'b1;
          end
          SEL_NONE: begin
            if (ev_val == CT_IDLE) id_q <= ID_HIGH;
            else if (ev_val == CT_NIB_LO || ev_val == CT_WR_B) id_q <= '0;
          end
          SEL_BURST: begin
            if (!ev_val[5]) bph_q <= BP_OFF;
            else if (bph_q == BP_RUN && ev_val == CT_BST_END) bph_q <= BP_TAIL;
            else if (bph_q == BP_TAIL && ev_val == CT_BST_EVN) bph_q <= BP_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign ide_alt = alt_q;
  assign ide_idx = idx_q;
  assign status  = (sel_q == SEL_NONE) ? {id_q, {NW{1'b0}}} : nibble_view(byte_q, hi_q);
  assign oe      = (bph_q != BP_OFF) && ctl_bit5;
  assign sel_o   = sel_q;
  assign bph_o   = bph_q;
endmodule

// File: rtl/ppide_bridge.sv
module ppide_bridge
  import ppide_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pp_ctrl,
  input  logic [DW-1:0] pp_data_in,
  output logic [DW-1:0] pp_data_out,
  output logic          pp_data_oe,
  output logic [DW-1:0] pp_status,
  output logic          ide_alt,
  output logic [IW-1:0] ide_idx,
  output logic [DW-1:0] ide_wdata,
  input  logic [DW-1:0] ide_rdata,
  output logic          ide_rd,
  output logic          ide_wr
);
  localparam int PLEN = 4;

  logic [CW-1:0] ctl_now, ctl_prev;
  logic [DW-1:0] dat_now, lat_cap, wr_cap;
  logic          ctl_ev, latch_hit, wr_hit, latch_drop;
  sel_e          sel_kind;
  bph_e          bph;

  ppide_sync #(.W(CW), .RST_VAL(CW'(CT_IDLE))) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(pp_ctrl), .q(ctl_now));
  ppide_sync #(.W(DW), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(pp_data_in), .q(dat_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_prev <= CW'(CT_IDLE);
    else        ctl_prev <= ctl_now;
  end
  assign ctl_ev = (ctl_now != ctl_prev);

  ppide_seqmatch #(.W(CW), .LEN(PLEN), .PATTERN(PAT_ADDR), .CAP_AGE(0)) u_match_addr (
    .clk(clk), .rst_n(rst_n), .ev(ctl_ev), .val(ctl_now), .data(dat_now),
    .hit(latch_hit), .cap(lat_cap));

  ppide_seqmatch #(.W(CW), .LEN(PLEN), .PATTERN(PAT_WRITE), .CAP_AGE(2)) u_match_wr (
    .clk(clk), .rst_n(rst_n), .ev(ctl_ev), .val(ctl_now), .data(dat_now),
    .hit(wr_hit), .cap(wr_cap));

  assign latch_drop = latch_hit && (decode_target(lat_cap).kind == SEL_DROP);

  ppide_xfer #(.DW(DW), .CW(CW), .IW(IW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .ev(ctl_ev), .ev_val(ctl_now), .ctl_bit5(ctl_now[5]),
    .latch_hit(latch_hit), .latch_byte(lat_cap), .wr_hit(wr_hit), .wr_byte(wr_cap),
    .rdata(ide_rdata), .ide_rd(ide_rd), .ide_wr(ide_wr), .ide_alt(ide_alt),
    .ide_idx(ide_idx), .ide_wdata(ide_wdata), .status(pp_status), .dout(pp_data_out),
    .oe(pp_data_oe), .sel_o(sel_kind), .bph_o(bph));
endmodule

// File: rtl/ppide_bridge_chk.sv
module ppide_bridge_chk
  import ppide_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_ev,
  input logic [7:0] ctl_now,
  input logic       latch_drop,
  input logic       ide_rd,
  input logic       ide_wr,
  input logic       pp_data_oe,
  input sel_e       sel_kind,
  input bph_e       bph
);
  a_r11_no_strobe_without_change: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ev |=> !(ide_rd || ide_wr));

  a_r5_write_on_closing_step: assert property (@(posedge clk) disable iff (!rst_n)
    ide_wr |-> $past(ctl_now) == CT_IDLE);

  a_r5_write_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ide_wr |=> !ide_wr);

  a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ide_rd && ide_wr));

  a_r9_drop_releases_lines: assert property (@(posedge clk) disable iff (!rst_n)
    latch_drop |=> !pp_data_oe);

  a_r7_drive_only_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    pp_data_oe |-> sel_kind == SEL_BURST);

  a_r8_no_read_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    ide_rd |-> ($past(sel_kind) == SEL_FILE) || ($past(bph) == BP_RUN));
endmodule

bind ppide_bridge ppide_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_ev(ctl_ev), .ctl_now(ctl_now),
  .latch_drop(latch_drop), .ide_rd(ide_rd), .ide_wr(ide_wr),
  .pp_data_oe(pp_data_oe), .sel_kind(sel_kind), .bph(bph));

// File: tb/ppide_bridge_bench.sv
module ppide_bridge_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pp_ctrl, pp_data_in, pp_data_out, pp_status, ide_wdata, ide_rdata;
  logic       pp_data_oe, ide_alt, ide_rd, ide_wr;
  logic [2:0] ide_idx;

  always #5 clk = ~clk;

  ppide_bridge u_ppide_bridge (
    .clk(clk), .rst_n(rst_n), .pp_ctrl(pp_ctrl), .pp_data_in(pp_data_in),
    .pp_data_out(pp_data_out), .pp_data_oe(pp_data_oe), .pp_status(pp_status),
    .ide_alt(ide_alt), .ide_idx(ide_idx), .ide_wdata(ide_wdata),
    .ide_rdata(ide_rdata), .ide_rd(ide_rd), .ide_wr(ide_wr));

  // drive-side stub: bank 0 register 0 is a counting data port
  logic [7:0] mem [16];
  logic [7:0] dport;
  int rd_seen = 0, wr_seen = 0;
  assign ide_rdata = (!ide_alt && ide_idx == 3'd0) ? dport : mem[{ide_alt, ide_idx}];
  always @(posedge clk) begin
    if (rst_n) begin
      if (ide_rd) begin
        rd_seen++;
        if (!ide_alt && ide_idx == 3'd0) dport <= dport + 8'd1;
      end
      if (ide_wr) begin
        wr_seen++;
        mem[{ide_alt, ide_idx}] <= ide_wdata;
      end
    end
  end

  // reference model
  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag = "R1";
  int hv[$], hd[$];
  int m_sel = 0, m_alt = 0, m_idx = 0, m_bph = 0, m_hi = 0;
  int m_byte = 0, m_id = 0, m_dout = 0, m_reads = 0, m_writes = 0, m_dport = 'h30;
  int m_mem[16];
  int last_ctrl = 4;

  function automatic int m_read();
    int v;
    if (m_alt == 0 && m_idx == 0) begin v = m_dport; m_dport = (m_dport + 1) & 255; end
    else v = m_mem[m_alt*8 + m_idx];
    m_reads++;
    return v;
  endfunction

  task automatic model_event(int v, int d);
    bit is_latch, is_write;
    hv.push_front(v); hd.push_front(d);
    if (hv.size() > 4) begin void'(hv.pop_back()); void'(hd.pop_back()); end
    is_latch = hv.size() == 4 && hv[0] == 'h04 && hv[1] == 'h0C && hv[2] == 'h0E && hv[3] == 'h0C;
    is_write = hv.size() == 4 && hv[0] == 'h04 && hv[1] == 'h05 && hv[2] == 'h07 && hv[3] == 'h05;
    if (is_latch) begin
      m_hi = 0;
      if (d >= 'h08 && d <= 'h17) begin m_sel = 1; m_alt = d / 16; m_idx = d % 8; m_bph = 0; end
      else if (d >= 'hC8 && d <= 'hD7) begin m_sel = 2; m_alt = (d >> 4) & 1; m_idx = d % 8; m_bph = 1; end
      else begin m_sel = 0; m_bph = 0; end
    end else if (m_sel == 1) begin
      if (is_write) begin m_mem[m_alt*8 + m_idx] = hd[2]; m_writes++; end
      if (v == 6) begin m_byte = m_read(); m_hi = 0; end
      else if (v == 4) m_hi = 1;
    end else if (m_sel == 0) begin
      if (v == 4) m_id = 4;
      else if (v == 6 || v == 7) m_id = 0;
    end else begin
      if ((v & 'h20) == 0) m_bph = 0;
      else if (m_bph == 1 && (v == 'hA6 || v == 'hA4)) m_dout = m_read();
      else if (m_bph == 1 && v == 'hAC) m_bph = 2;
      else if (m_bph == 2 && v == 'hA4) m_bph = 3;
    end
  endtask

  task automatic check(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_outs();
    int es, eo;
    es = (m_sel == 0) ? (m_id << 4) : (m_hi ? (m_byte & 'hF0) : ((m_byte & 'h0F) << 4));
    eo = (m_bph != 0 && (last_ctrl & 'h20) != 0) ? 1 : 0;
    check(pp_status == 8'(es), "status", pp_status, es);
    check(pp_data_oe == 1'(eo), "oe", pp_data_oe, eo);
    if (eo == 1) check(pp_data_out == 8'(m_dout), "data_out", pp_data_out, m_dout);
  endtask

  task automatic check_counts();
    check(rd_seen == m_reads, "read strobes", rd_seen, m_reads);
    check(wr_seen == m_writes, "write strobes", wr_seen, m_writes);
  endtask

  task automatic step(int v, int hold = 6);
    @(negedge clk);
    pp_ctrl = 8'(v);
    if (v != last_ctrl) model_event(v, pp_data_in);
    last_ctrl = v;
    repeat (hold - 1) @(negedge clk);
    compare_outs();
    @(negedge clk);
    compare_outs();
  endtask

  task automatic set_data(int d);
    @(negedge clk);
    pp_data_in = 8'(d);
  endtask

  task automatic latch(int a);
    set_data(a);
    step('h0C); step('h0E); step('h0E); step('h0C); step('h04);
  endtask

  task automatic wr_reg(int val);
    set_data(val);
    step('h05); step('h07); step('h05); step('h04);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = 8'(8'h90 + i); m_mem[i] = 'h90 + i; end
    dport = 8'h30;
    rst_n = 1'b0; pp_ctrl = 8'h04; pp_data_in = 8'h00;
    repeat (4) @(negedge clk);
    tag = "R1";
    check(pp_status == 8'h00, "reset status", pp_status, 0);
    check(pp_data_oe == 1'b0, "reset oe", pp_data_oe, 0);
    check(ide_rd == 1'b0 && ide_wr == 1'b0, "reset strobes", {ide_rd, ide_wr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    tag = "R10"; // identification probe before any selection
    set_data('h04); step('h06); step('h07); step('h04);
    check(pp_status[6] == 1'b1, "probe bit6 high", pp_status[6], 1);

    tag = "R5"; // write 0x5A to bank 0 reg 3, data changed after the 0x07 step
    latch('h0B);
    set_data('h5A); step('h05); step('h07); set_data('h11); step('h05); step('h04);
    check_counts();

    tag = "R3"; // read reg 3 back as two nibbles
    step('h06); check(pp_status == 8'hA0, "low nibble", pp_status, 'hA0);
    step('h04); check(pp_status == 8'h50, "high nibble", pp_status, 'h50);
    check_counts();

    tag = "R6"; // broken write: 5,7 then address step
    set_data('h77); step('h05); step('h07); step('h0C); step('h04);
    step('h06); step('h04); check_counts();
    tag = "R6"; // broken latch of reg 4: C,E then read step
    set_data('h0C); step('h0C); step('h0E); step('h06);
    check(pp_status == 8'hA0, "selection kept", pp_status, 'hA0);
    step('h04); check_counts();

    tag = "R2"; // bank 1 register 2
    latch('h12); step('h06); step('h04); check_counts();
    tag = "R2"; // write then read bank 1 register 5
    latch('h15); wr_reg('hC3); step('h06); step('h04); check_counts();

    tag = "R4"; // data port, three pairs after one latch
    latch('h08);
    for (int k = 0; k < 3; k++) begin step('h06); step('h04); end
    check_counts();

    tag = "R11"; // held read step counts once
    step('h06, 40); step('h04, 30); check_counts();

    tag = "R7"; // byte burst on the data port
    latch('hC8); set_data('hFF);
    step('hA6); step('hA4); step('hA6); step('hA4);
    check_counts();
    tag = "R8";
    step('hAC); step('hA4); check_counts();
    step('h04); check(pp_data_oe == 1'b0, "released", pp_data_oe, 0);

    tag = "R7"; // burst on bank 1 register 1
    latch('hD1); set_data('hFF); step('hA6); step('hA4); check_counts();

    tag = "R9"; // disconnect then read step
    latch('h20); step('h06); step('h04); check_counts();
    check(pp_data_oe == 1'b0, "oe after drop", pp_data_oe, 0);

    tag = "R10"; // probe again after disconnect
    set_data('h04); step('h06); step('h07);
    check(pp_status[6] == 1'b0, "probe bit6 low", pp_status[6], 0);
    step('h04); check_counts();

    done = 1;
    finish_run();
  end
endmodule